// File: doc/BRIEF.md
# Floating-Point State Dump and Reinitialize Sequencer

This block empties the architectural state of a floating-point unit into memory and then puts the unit back into its power-on condition. When a one-cycle start pulse arrives, the sequencer waits until the unit reports that every earlier operation has finished. It then streams 16-bit words out through a word-addressed write port that has a ready signal. Once the last word is accepted, it raises a single load strobe, and the live registers pick up their default values on that strobe.

A mode input picks one of two variants. In the checking variant the sequencer looks for a pending unmasked exception first. If one is pending, it reports a fault and touches neither memory nor the registers. The no-wait variant skips that check. An operating system uses the block to switch contexts, or a handler uses it to hand a clean unit to other code.

The image has two parts. The environment comes first as eight beats. The eight 80-bit stack registers follow, five beats each. The whole image is 48 consecutive word addresses counted from a base address.

Top module: `fpu_state_saver`

## Requirements
- R1: While reset is held and after it is released, `busy`, `wrValid`, `initLoad`, `done` and `fault` are all low.
- R2: After a start, no write is issued while `fpuIdle` is low. The dump begins only once `fpuIdle` is seen high.
- R3: The first eight beats go to `baseAddr+0` through `baseAddr+7` and carry, in this order: control word, status word (with its condition bits as they stood), tag word, data pointer bits 15:0, data pointer bits 31:16, instruction pointer bits 15:0, instruction pointer bits 31:16, last opcode.
- R4: Next come ST(0) through ST(7) in ascending order, at `baseAddr+8` through `baseAddr+47`. Each 80-bit register, taken from `stackFlat[i*80 +: 80]`, goes out as five 16-bit beats with bits 15:0 first.
- R5: A beat is held with the same address while `wrReady` is low. Each accepted beat moves the address up by exactly one.
- R6: `initLoad` is high for exactly the one cycle that follows acceptance of the last beat. In that cycle the reset values are: control 0x037F, status 0 (condition bits cleared), tag 0xFFFF, and data pointer, instruction pointer and opcode all 0.
- R7: `done` is a one-cycle pulse in the cycle after `initLoad`, with `fault` low.
- R8: In checking mode (`noWait`=0), if `excPending` is high when the unit is idle, the sequencer pulses `done` with `fault` high. It issues no write and no `initLoad`.
- R9: In no-wait mode (`noWait`=1), `excPending` has no effect and the full dump and reinitialization take place.
- R10: A start pulse that arrives while `busy` is high is ignored. No second dump follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to dump and reinitialize |
| noWait | input | 1 | 1 = skip the pending-exception check |
| fpuIdle | input | 1 | Unit has finished all earlier operations |
| excPending | input | 1 | Unmasked exception pending |
| baseAddr | input | 16 | Word address of the first beat |
| ctrlWord | input | 16 | Live control word |
| statWord | input | 16 | Live status word |
| tagWord | input | 16 | Live tag word |
| dataPtr | input | 32 | Live data pointer |
| instPtr | input | 32 | Live instruction pointer |
| lastOpcode | input | 16 | Live last opcode |
| stackFlat | input | 640 | ST(i) at bits i*80 +: 80 |
| wrReady | input | 1 | Write port accepts the current beat |
| wrValid | output | 1 | Beat is presented |
| wrAddr | output | 16 | Beat word address |
| wrData | output | 16 | Beat data |
| initLoad | output | 1 | Load the reset values into the live registers |
| initCtrlWord | output | 16 | Reset control word |
| initStatWord | output | 16 | Reset status word |
| initTagWord | output | 16 | Reset tag word |
| initDataPtr | output | 32 | Reset data pointer |
| initInstPtr | output | 32 | Reset instruction pointer |
| initOpcode | output | 16 | Reset opcode |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Qualifies `done`: refused due to a pending exception |

## Verification
If `fpuIdle` is already high, the first beat appears two edges after the edge that samples `start`. After that, each beat is retired on the edge at which `wrReady` is high. `initLoad` follows one edge after the last acceptance, and `done` one edge after that. The fault path reaches `done` two edges after `start`. The bench samples every output on the falling edge. It pops one expected beat from the queue for each accepted beat, and it arms one-cycle flags so that it looks for `initLoad` and then `done` in exactly the next sampled cycle. During a withheld `fpuIdle` or a stalled beat, it checks on each falling edge that nothing has moved.

// File: rtl/fsave_pkg.sv
package fsave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_WRITE,
    ST_INIT,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic clrBeat;
    logic advBeat;
  } dpStrobe_t;

  localparam int ENV_BEATS = 8;
  localparam logic [15:0] RESET_CTRL = 16'h037F;
  localparam logic [15:0] RESET_TAG  = 16'hFFFF;
endpackage

// File: rtl/fsave_ctrl.sv
module fsave_ctrl
  import fsave_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      noWait,
  input  logic      fpuIdle,
  input  logic      excPending,
  input  logic      wrReady,
  input  logic      lastBeat,
  output dpStrobe_t strobe,
  output logic      wrValid,
  output logic      initLoad,
  output logic      done,
  output logic      fault,
  output logic      busy
);
  seqState_t state, stateNext;
  logic noWaitQ;
  logic faultQ, faultNext;

  always_comb begin
    stateNext = state;
    faultNext = faultQ;
    unique case (state)
      ST_IDLE: if (start) begin
        stateNext = ST_WAIT;
        faultNext = 1'b0;
      end
      ST_WAIT: if (fpuIdle) begin
        if (!noWaitQ && excPending) begin
          stateNext = ST_DONE;
          faultNext = 1'b1;
        end else begin
          stateNext = ST_WRITE;
        end
      end
      ST_WRITE: if (wrReady && lastBeat) stateNext = ST_INIT;
      ST_INIT:  stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      faultQ  <= 1'b0;
      noWaitQ <= 1'b0;
    end else begin
      state  <= stateNext;
      faultQ <= faultNext;
      if (state == ST_IDLE && start) noWaitQ <= noWait;
    end
  end

  assign strobe.clrBeat = (state == ST_IDLE);
  assign strobe.advBeat = (state == ST_WRITE) && wrReady;
  assign wrValid  = (state == ST_WRITE);
  assign initLoad = (state == ST_INIT);
  assign done     = (state == ST_DONE);
  assign fault    = (state == ST_DONE) && faultQ;
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/fsave_dp.sv
module fsave_dp
  import fsave_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int REG_W    = 80,
  parameter int NUM_REGS = 8,
  parameter int AW       = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [AW-1:0]              baseAddr,
  input  logic [WORD_W-1:0]          ctrlWord,
  input  logic [WORD_W-1:0]          statWord,
  input  logic [WORD_W-1:0]          tagWord,
  input  logic [2*WORD_W-1:0]        dataPtr,
  input  logic [2*WORD_W-1:0]        instPtr,
  input  logic [WORD_W-1:0]          lastOpcode,
  input  logic [NUM_REGS*REG_W-1:0]  stackFlat,
  output logic [AW-1:0]              wrAddr,
  output logic [WORD_W-1:0]          wrData,
  output logic                       lastBeat,
  output logic [WORD_W-1:0]          initCtrlWord,
  output logic [WORD_W-1:0]          initStatWord,
  output logic [WORD_W-1:0]          initTagWord,
  output logic [2*WORD_W-1:0]        initDataPtr,
  output logic [2*WORD_W-1:0]        initInstPtr,
  output logic [WORD_W-1:0]          initOpcode
);
  localparam int BPR   = REG_W / WORD_W;
  localparam int TOTAL = ENV_BEATS + NUM_REGS * BPR;
  localparam int BW    = $clog2(TOTAL);
  localparam int RIW   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int PW    = (BPR > 1) ? $clog2(BPR) : 1;
  localparam int IW    = $clog2(NUM_REGS * REG_W);
  localparam int EW    = $clog2(ENV_BEATS);

  logic [BW-1:0]  beat;
  logic [RIW-1:0] regIdx;
  logic [PW-1:0]  part;
  logic [IW-1:0]  bitBase;
  logic [WORD_W-1:0] envWord [ENV_BEATS];
  logic inRegs;

  assign inRegs = (beat >= BW'(ENV_BEATS));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrBeat) begin
      beat   <= '0;
      regIdx <= '0;
      part   <= '0;
    end else if (strobe.advBeat) begin
      beat <= beat + 1'b1;
      if (inRegs) begin
        if (part == PW'(BPR - 1)) begin
          part   <= '0;
          regIdx <= regIdx + 1'b1;
        end else begin
          part <= part + 1'b1;
        end
      end
    end
  end

  always_comb begin
    envWord[0] = ctrlWord;
    envWord[1] = statWord;
    envWord[2] = tagWord;
    envWord[3] = dataPtr[WORD_W-1:0];
    envWord[4] = dataPtr[2*WORD_W-1:WORD_W];
    envWord[5] = instPtr[WORD_W-1:0];
    envWord[6] = instPtr[2*WORD_W-1:WORD_W];
    envWord[7] = lastOpcode;
  end

  assign bitBase = IW'(regIdx) * IW'(REG_W) + IW'(part) * IW'(WORD_W);
  assign wrData  = inRegs ? stackFlat[bitBase +: WORD_W] : envWord[beat[EW-1:0]];
  assign wrAddr  = baseAddr + AW'(beat);
  assign lastBeat = (beat == BW'(TOTAL - 1));

  assign initCtrlWord = WORD_W'(RESET_CTRL);
  assign initStatWord = '0;
  assign initTagWord  = WORD_W'(RESET_TAG);
  assign initDataPtr  = '0;
  assign initInstPtr  = '0;
  assign initOpcode   = '0;
endmodule

// File: rtl/fpu_state_saver.sv
module fpu_state_saver
  import fsave_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int REG_W    = 80,
  parameter int NUM_REGS = 8,
  parameter int AW       = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic                      noWait,
  input  logic                      fpuIdle,
  input  logic                      excPending,
  input  logic [AW-1:0]             baseAddr,
  input  logic [WORD_W-1:0]         ctrlWord,
  input  logic [WORD_W-1:0]         statWord,
  input  logic [WORD_W-1:0]         tagWord,
  input  logic [2*WORD_W-1:0]       dataPtr,
  input  logic [2*WORD_W-1:0]       instPtr,
  input  logic [WORD_W-1:0]         lastOpcode,
  input  logic [NUM_REGS*REG_W-1:0] stackFlat,
  input  logic                      wrReady,
  output logic                      wrValid,
  output logic [AW-1:0]             wrAddr,
  output logic [WORD_W-1:0]         wrData,
  output logic                      initLoad,
  output logic [WORD_W-1:0]         initCtrlWord,
  output logic [WORD_W-1:0]         initStatWord,
  output logic [WORD_W-1:0]         initTagWord,
  output logic [2*WORD_W-1:0]       initDataPtr,
  output logic [2*WORD_W-1:0]       initInstPtr,
  output logic [WORD_W-1:0]         initOpcode,
  output logic                      busy,
  output logic                      done,
  output logic                      fault
);
  dpStrobe_t strobe;
  logic lastBeat;

  fsave_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .noWait(noWait),
    .fpuIdle(fpuIdle), .excPending(excPending), .wrReady(wrReady),
    .lastBeat(lastBeat), .strobe(strobe), .wrValid(wrValid),
    .initLoad(initLoad), .done(done), .fault(fault), .busy(busy)
  );

  fsave_dp #(.WORD_W(WORD_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseAddr(baseAddr),
    .ctrlWord(ctrlWord), .statWord(statWord), .tagWord(tagWord),
    .dataPtr(dataPtr), .instPtr(instPtr), .lastOpcode(lastOpcode),
    .stackFlat(stackFlat), .wrAddr(wrAddr), .wrData(wrData),
    .lastBeat(lastBeat), .initCtrlWord(initCtrlWord),
    .initStatWord(initStatWord), .initTagWord(initTagWord),
    .initDataPtr(initDataPtr), .initInstPtr(initInstPtr),
    .initOpcode(initOpcode)
  );
endmodule

// File: rtl/fsave_checker.sv
module fsave_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          wrValid,
  input logic          wrReady,
  input logic [AW-1:0] wrAddr,
  input logic          initLoad,
  input logic          done,
  input logic          fault
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!wrValid && !initLoad && !done));

  assert_hold_beat_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr)));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady) |=> (initLoad || (wrValid && wrAddr == $past(wrAddr) + 1'b1)));

  assert_init_after_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    initLoad |-> $past(wrValid && wrReady));

  assert_done_follows_init_R7: assert property (@(posedge clk) disable iff (!rstN)
    initLoad |=> (done && !fault));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_fault_no_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (done && !$past(wrValid)));
endmodule

bind fpu_state_saver fsave_checker #(.AW(AW)) u_fsave_checker (
  .clk(clk), .rstN(rstN), .busy(busy), .wrValid(wrValid), .wrReady(wrReady),
  .wrAddr(wrAddr), .initLoad(initLoad), .done(done), .fault(fault)
);

// File: tb/fpu_state_saver_bench.sv
module fpu_state_saver_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk, rstN, start, noWait, fpuIdle, excPending, wrReady;
  logic [AW-1:0] baseAddr;
  logic [15:0] ctrlWord, statWord, tagWord, lastOpcode;
  logic [31:0] dataPtr, instPtr;
  logic [639:0] stackFlat;
  logic wrValid, initLoad, busy, done, fault;
  logic [AW-1:0] wrAddr;
  logic [15:0] wrData, initCtrlWord, initStatWord, initTagWord, initOpcode;
  logic [31:0] initDataPtr, initInstPtr;

  fpu_state_saver u_fpu_state_saver (.*);

  int checks = 0, fails = 0, cyc = 0;
  int writeCount = 0, initCount = 0, beatNo = 0;
  bit readyAlways = 0;
  logic [31:0] expQ[$];
  bit pendInit = 0, pendDone = 0, holdPend = 0;
  logic [AW-1:0] holdAddr;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1 wrReady = readyAlways ? 1'b1 : ((cyc % 3) != 1);
  end

  // monitor: scoreboard pop and cycle-exact follow-ups
  always @(negedge clk) begin
    if (rstN) begin
      if (pendInit) begin
        chk(initLoad, "R6", "initLoad after last beat", initLoad, 1);
      end else if (initLoad) begin
        chk(0, "R6", "initLoad without last beat", 1, 0);
      end
      if (initLoad)
        chk({initCtrlWord, initStatWord, initTagWord, initDataPtr, initInstPtr, initOpcode} ==
            {16'h037F, 16'h0, 16'hFFFF, 32'h0, 32'h0, 16'h0},
            "R6", "reset values", initCtrlWord, 16'h037F);
      if (pendDone) chk(done && !fault, "R7", "done after initLoad", {done, fault}, 2'b10);
      if (holdPend) chk(wrValid && wrAddr == holdAddr, "R5", "stalled beat held", wrAddr, holdAddr);
      pendInit = 0;
      pendDone = initLoad;
      holdPend = wrValid && !wrReady;
      holdAddr = wrAddr;
      if (initLoad) initCount++;
      if (wrValid && wrReady) begin
        writeCount++;
        if (expQ.size() == 0) begin
          chk(0, "R10", "unexpected write", wrAddr, 0);
        end else begin
          logic [31:0] e;
          e = expQ.pop_front();
          chk({wrAddr, wrData} == e, (beatNo < 8) ? "R3" : "R4",
              $sformatf("beat %0d addr/data", beatNo), {wrAddr, wrData}, e);
          beatNo++;
          if (expQ.size() == 0) pendInit = 1;
        end
      end
    end
  end

  task automatic runSave(bit nw, bit exc, int idleDelay, bit expFault, int restartAt, int seed);
    int w0, i0;
    bit seenDone;
    baseAddr   = AW'(16'h0100 * seed + 16'h0020);
    ctrlWord   = 16'h0270 + 16'(seed);
    statWord   = 16'h4700 | 16'(seed);
    tagWord    = 16'h5A00 + 16'(seed);
    dataPtr    = 32'hD0A1_0000 + 32'(seed * 3);
    instPtr    = 32'h1E57_0000 + 32'(seed * 5);
    lastOpcode = 16'h07C0 + 16'(seed);
    for (int j = 0; j < 40; j++) stackFlat[j*16 +: 16] = 16'(seed * 1000 + j * 37 + 5);
    beatNo = 0;
    if (!expFault) begin
      expQ.push_back({baseAddr + 16'd0, ctrlWord});
      expQ.push_back({baseAddr + 16'd1, statWord});
      expQ.push_back({baseAddr + 16'd2, tagWord});
      expQ.push_back({baseAddr + 16'd3, dataPtr[15:0]});
      expQ.push_back({baseAddr + 16'd4, dataPtr[31:16]});
      expQ.push_back({baseAddr + 16'd5, instPtr[15:0]});
      expQ.push_back({baseAddr + 16'd6, instPtr[31:16]});
      expQ.push_back({baseAddr + 16'd7, lastOpcode});
      for (int r = 0; r < 8; r++)
        for (int p = 0; p < 5; p++)
          expQ.push_back({baseAddr + 16'(8 + r * 5 + p), stackFlat[r*80 + p*16 +: 16]});
    end
    w0 = writeCount;
    i0 = initCount;
    @(negedge clk);
    fpuIdle = (idleDelay == 0);
    noWait = nw;
    excPending = exc;
    start = 1;
    @(negedge clk);
    start = 0;
    seenDone = 0;
    for (int k = 0; k < 600 && !seenDone; k++) begin
      if (k < idleDelay) chk(!wrValid, "R2", "no write before idle", wrValid, 0);
      if (k >= idleDelay) fpuIdle = 1;
      start = (k == restartAt);
      if (done) begin
        seenDone = 1;
        chk(fault == expFault, expFault ? "R8" : "R7", "fault at done", fault, expFault);
      end
      @(negedge clk);
    end
    start = 0;
    chk(seenDone, "R7", "done reached", seenDone, 1);
    if (expFault) begin
      chk(writeCount == w0, "R8", "no writes on fault", writeCount - w0, 0);
      chk(initCount == i0, "R8", "no initLoad on fault", initCount - i0, 0);
    end else begin
      chk(expQ.size() == 0, nw && exc ? "R9" : "R4", "all beats written", expQ.size(), 0);
      chk(initCount == i0 + 1, "R6", "one initLoad", initCount - i0, 1);
    end
    repeat (6) @(negedge clk);
    chk(!busy && !wrValid, "R10", "back to idle", {busy, wrValid}, 0);
    chk(writeCount == w0 + (expFault ? 0 : 48), "R10", "write count", writeCount - w0, expFault ? 0 : 48);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 0; start = 0; noWait = 0; fpuIdle = 0; excPending = 0; wrReady = 0;
    baseAddr = '0; ctrlWord = '0; statWord = '0; tagWord = '0;
    dataPtr = '0; instPtr = '0; lastOpcode = '0; stackFlat = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !wrValid && !initLoad && !done && !fault, "R1", "outputs in reset",
        {busy, wrValid, initLoad, done, fault}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !wrValid && !done, "R1", "idle after reset", {busy, wrValid, done}, 0);
    // no-wait mode ignores pending exception, stalled ready pattern
    runSave(1'b1, 1'b1, 0, 1'b0, -1, 1);
    // checking mode, unit busy for a while, no exception
    runSave(1'b0, 1'b0, 6, 1'b0, -1, 2);
    // checking mode with pending exception: fault path
    runSave(1'b0, 1'b1, 0, 1'b1, -1, 3);
    // back-to-back beats, extra start during the dump
    readyAlways = 1;
    runSave(1'b0, 1'b0, 0, 1'b0, 12, 4);
    // fault path after waiting for idle
    readyAlways = 0;
    runSave(1'b0, 1'b1, 4, 1'b1, -1, 5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule